// File: doc/BRIEF.md
# Secure Thread Save-Frame Tracker

This block keeps the save-frame bookkeeping for one thread of a protected execution context. It holds the index of the frame that the next interruption will fill. Each frame lies in a stack of equally sized frames that begins at a configured base address. The block answers three single-cycle event strobes. An enter request is accepted only while a free frame remains. An asynchronous exit reports the byte addresses of the regions where the interrupted state must be written, then moves the index up. A resume moves the index down and reports the address of the frame to restore from.

A frame is a whole number of 4 KB pages. Its extended-state area starts at the frame's first byte. The 176-byte general-register area sits at the very top of the frame. A miscellaneous area of configurable size sits directly below the general-register area. The block only produces addresses, the index and a pass/fail flag. Moving the data is done elsewhere.

Top module: `save_frame_tracker`

## Requirements
- R1: While `rst` is high at a clock edge, `curIdx`, `done`, `fail` and all four address outputs become 0, and so do the internal configuration copies.
- R2: An exit (`exitReq`) with `curIdx` below the frame count loads `xsaveAddr` = (base with bits 11:0 cleared) + `curIdx` × pages × 4096 from the old index. It then increments `curIdx` by one and gives `fail` = 0.
- R3: On that same accepted exit, `gprAddr` = frame address + pages × 4096 − 176 and `miscAddr` = `gprAddr` − misc bytes. The low 12 bits of `gprAddr` are therefore always 3920.
- R4: An exit with `curIdx` ≥ the frame count gives `fail` = 1. `curIdx` and all address outputs keep their values.
- R5: A resume (`resumeReq`) with `curIdx` > 0 decrements `curIdx` and loads `restoreAddr` = aligned base + (`curIdx` − 1) × pages × 4096, with `fail` = 0.
- R6: A resume with `curIdx` = 0 gives `fail` = 1. `curIdx` stays 0 and `restoreAddr` keeps its value.
- R7: An enter (`enterReq`) gives `fail` = 0 when `curIdx` is below the frame count and `fail` = 1 otherwise. The index and the addresses never change on an enter.
- R8: `done` is 1 in exactly the cycle after a strobe cycle, and the outputs of that event are valid in the same cycle. After a cycle with no strobe, `done` and `fail` are both 0. If several strobes come together, exit wins over resume and resume wins over enter.
- R9: The configuration inputs (base, frame count, pages, misc bytes) are captured only at edges where no strobe is high. An event uses the values captured at the last such edge, and a value presented during a strobe cycle is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enterReq | input | 1 | Enter strobe |
| exitReq | input | 1 | Asynchronous-exit strobe |
| resumeReq | input | 1 | Resume strobe |
| cfgBase | input | ADDR_W (48) | Frame stack base address; bits 11:0 ignored |
| cfgFrameCount | input | IDX_W (4) | Number of frames available |
| cfgFramePages | input | PAGES_W (8) | Frame size in 4 KB pages |
| cfgMiscBytes | input | MISC_W (12) | Size of the miscellaneous area in bytes |
| done | output | 1 | Event completed (one-cycle pulse) |
| fail | output | 1 | Event rejected; valid with `done` |
| curIdx | output | IDX_W (4) | Current frame index |
| xsaveAddr | output | ADDR_W (48) | Extended-state area address of the last saved frame |
| gprAddr | output | ADDR_W (48) | General-register area address of the last saved frame |
| miscAddr | output | ADDR_W (48) | Miscellaneous area address of the last saved frame |
| restoreAddr | output | ADDR_W (48) | Frame address for the last resume |

## Verification
The hardest situations to reach are the two ends of the frame stack. One is an exit when every frame is already used. The other is a resume with nothing saved. Both are also needed with configuration edits that land in the same cycle as a strobe. Directed runs first fill the stack with exits up to the count and push one more, then drain it with resumes below zero. They also use a zero frame count and change the configuration inside a strobe cycle. A long stretch of mixed strobes, biased toward exits, then meets occasional configuration changes, and a behavioural model is compared on every clock.

// File: rtl/sft_pkg.sv
package sft_pkg;
  typedef struct packed {
    logic cfgLatch;
    logic saveFrame;
    logic restoreFrame;
  } sftStrobes_t;
endpackage

// File: rtl/sft_ctrl.sv
module sft_ctrl
  import sft_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enterReq,
  input  logic             exitReq,
  input  logic             resumeReq,
  input  logic [IDX_W-1:0] frameCount,
  output sftStrobes_t      strobes,
  output logic [IDX_W-1:0] curIdx,
  output logic             done,
  output logic             fail
);
  logic anyEv;
  logic hasFree;
  logic hasSaved;
  logic evFail;

  assign anyEv    = enterReq | exitReq | resumeReq;
  assign hasFree  = curIdx < frameCount;
  assign hasSaved = curIdx != '0;

  always_comb begin
    strobes.cfgLatch     = !anyEv;
    strobes.saveFrame    = exitReq & hasFree;
    strobes.restoreFrame = !exitReq & resumeReq & hasSaved;
    if (exitReq)        evFail = !hasFree;
    else if (resumeReq) evFail = !hasSaved;
    else if (enterReq)  evFail = !hasFree;
    else                evFail = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      curIdx <= '0;
      done   <= 1'b0;
      fail   <= 1'b0;
    end else begin
      done <= anyEv;
      fail <= evFail;
      if (strobes.saveFrame)         curIdx <= curIdx + 1'b1;
      else if (strobes.restoreFrame) curIdx <= curIdx - 1'b1;
    end
  end

  AST_EXIT_STEP: assert property (@(posedge clk) disable iff (rst)
    (exitReq && curIdx < frameCount) |=> (curIdx == $past(curIdx) + 1'b1) && !fail); // R2
  AST_FULL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (exitReq && !(curIdx < frameCount)) |=> fail && $stable(curIdx)); // R4
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    (resumeReq && !exitReq && curIdx == '0) |=> fail && curIdx == '0); // R6
  AST_ENTER_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (enterReq && !exitReq && !resumeReq) |=> $stable(curIdx)); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    anyEv |=> done); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !anyEv |=> !done && !fail); // R8
endmodule

// File: rtl/sft_datapath.sv
module sft_datapath
  import sft_pkg::*;
#(
  parameter int ADDR_W  = 48,
  parameter int IDX_W   = 4,
  parameter int PAGES_W = 8,
  parameter int MISC_W  = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  sftStrobes_t        strobes,
  input  logic [IDX_W-1:0]   curIdx,
  input  logic [ADDR_W-1:0]  cfgBase,
  input  logic [IDX_W-1:0]   cfgFrameCount,
  input  logic [PAGES_W-1:0] cfgFramePages,
  input  logic [MISC_W-1:0]  cfgMiscBytes,
  output logic [IDX_W-1:0]   shCount,
  output logic [ADDR_W-1:0]  xsaveAddr,
  output logic [ADDR_W-1:0]  gprAddr,
  output logic [ADDR_W-1:0]  miscAddr,
  output logic [ADDR_W-1:0]  restoreAddr
);
  localparam int PAGE_SH   = 12;
  localparam int GPR_BYTES = 176;
  localparam int PROD_W    = IDX_W + PAGES_W;
  localparam logic [ADDR_W-1:0]  PAGE_MASK = ADDR_W'((1 << PAGE_SH) - 1);
  localparam logic [PAGE_SH-1:0] GPR_LOW   = PAGE_SH'((1 << PAGE_SH) - GPR_BYTES);

  logic [ADDR_W-1:0]  shBase;
  logic [PAGES_W-1:0] shPages;
  logic [MISC_W-1:0]  shMisc;

  logic [IDX_W-1:0]  frameIdx;
  logic [PROD_W-1:0] offPages;
  logic [ADDR_W-1:0] baseAligned;
  logic [ADDR_W-1:0] frameAddr;
  logic [ADDR_W-1:0] frameBytes;
  logic [ADDR_W-1:0] gprNext;
  logic [ADDR_W-1:0] miscNext;

  always_comb begin
    frameIdx    = strobes.restoreFrame ? curIdx - 1'b1 : curIdx;
    offPages    = PROD_W'(frameIdx) * PROD_W'(shPages);
    baseAligned = shBase & ~PAGE_MASK;
    frameAddr   = baseAligned + ADDR_W'({offPages, {PAGE_SH{1'b0}}});
    frameBytes  = ADDR_W'({shPages, {PAGE_SH{1'b0}}});
    gprNext     = frameAddr + frameBytes - ADDR_W'(GPR_BYTES);
    miscNext    = gprNext - ADDR_W'(shMisc);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shBase      <= '0;
      shCount     <= '0;
      shPages     <= '0;
      shMisc      <= '0;
      xsaveAddr   <= '0;
      gprAddr     <= '0;
      miscAddr    <= '0;
      restoreAddr <= '0;
    end else begin
      if (strobes.cfgLatch) begin
        shBase  <= cfgBase;
        shCount <= cfgFrameCount;
        shPages <= cfgFramePages;
        shMisc  <= cfgMiscBytes;
      end
      if (strobes.saveFrame) begin
        xsaveAddr <= frameAddr;
        gprAddr   <= gprNext;
        miscAddr  <= miscNext;
      end
      if (strobes.restoreFrame) restoreAddr <= frameAddr;
    end
  end

  AST_XSAVE_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    strobes.saveFrame |=> xsaveAddr[PAGE_SH-1:0] == '0); // R2
  AST_GPR_PAGE_END: assert property (@(posedge clk) disable iff (rst)
    strobes.saveFrame |=> gprAddr[PAGE_SH-1:0] == GPR_LOW); // R3
  AST_SAVE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !strobes.saveFrame |=> $stable(xsaveAddr) && $stable(gprAddr) && $stable(miscAddr)); // R4
  AST_RESTORE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !strobes.restoreFrame |=> $stable(restoreAddr)); // R6
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
    !strobes.cfgLatch |=> $stable(shPages) && $stable(shCount) && $stable(shMisc) && $stable(shBase)); // R9
endmodule

// File: rtl/save_frame_tracker.sv
module save_frame_tracker
  import sft_pkg::*;
#(
  parameter int ADDR_W  = 48,
  parameter int IDX_W   = 4,
  parameter int PAGES_W = 8,
  parameter int MISC_W  = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               enterReq,
  input  logic               exitReq,
  input  logic               resumeReq,
  input  logic [ADDR_W-1:0]  cfgBase,
  input  logic [IDX_W-1:0]   cfgFrameCount,
  input  logic [PAGES_W-1:0] cfgFramePages,
  input  logic [MISC_W-1:0]  cfgMiscBytes,
  output logic               done,
  output logic               fail,
  output logic [IDX_W-1:0]   curIdx,
  output logic [ADDR_W-1:0]  xsaveAddr,
  output logic [ADDR_W-1:0]  gprAddr,
  output logic [ADDR_W-1:0]  miscAddr,
  output logic [ADDR_W-1:0]  restoreAddr
);
  sftStrobes_t      strobes;
  logic [IDX_W-1:0] shCount;

  sft_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .enterReq   (enterReq),
    .exitReq    (exitReq),
    .resumeReq  (resumeReq),
    .frameCount (shCount),
    .strobes    (strobes),
    .curIdx     (curIdx),
    .done       (done),
    .fail       (fail)
  );

  sft_datapath #(
    .ADDR_W (ADDR_W),
    .IDX_W  (IDX_W),
    .PAGES_W(PAGES_W),
    .MISC_W (MISC_W)
  ) u_dp (
    .clk          (clk),
    .rst          (rst),
    .strobes      (strobes),
    .curIdx       (curIdx),
    .cfgBase      (cfgBase),
    .cfgFrameCount(cfgFrameCount),
    .cfgFramePages(cfgFramePages),
    .cfgMiscBytes (cfgMiscBytes),
    .shCount      (shCount),
    .xsaveAddr    (xsaveAddr),
    .gprAddr      (gprAddr),
    .miscAddr     (miscAddr),
    .restoreAddr  (restoreAddr)
  );
endmodule

// File: tb/save_frame_tracker_test.sv
module save_frame_tracker_test;
  localparam int ADDR_W = 48;
  localparam longint AMASK = (64'd1 << ADDR_W) - 1;

  logic clk = 1'b0;
  logic rst;
  logic enterReq, exitReq, resumeReq;
  logic [47:0] cfgBase;
  logic [3:0]  cfgFrameCount;
  logic [7:0]  cfgFramePages;
  logic [11:0] cfgMiscBytes;
  logic done, fail;
  logic [3:0]  curIdx;
  logic [47:0] xsaveAddr, gprAddr, miscAddr, restoreAddr;

  int nCmp = 0;
  int nBad = 0;

  // behavioural model state
  int     mIdx;
  longint mBase, mCount, mPages, mMisc;
  longint mX, mG, mM, mR;
  bit     mDone, mFail;

  always #5 clk = ~clk;

  save_frame_tracker uut (
    .clk(clk), .rst(rst), .enterReq(enterReq), .exitReq(exitReq), .resumeReq(resumeReq),
    .cfgBase(cfgBase), .cfgFrameCount(cfgFrameCount), .cfgFramePages(cfgFramePages),
    .cfgMiscBytes(cfgMiscBytes), .done(done), .fail(fail), .curIdx(curIdx),
    .xsaveAddr(xsaveAddr), .gprAddr(gprAddr), .miscAddr(miscAddr), .restoreAddr(restoreAddr)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    nCmp++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic compareAll(input string tag, input string addrTag);
    chk(tag, "curIdx", longint'(curIdx), longint'(mIdx));
    chk(tag, "done", longint'(done), longint'(mDone));
    chk(tag, "fail", longint'(fail), longint'(mFail));
    chk(addrTag, "xsaveAddr", longint'(xsaveAddr), mX);
    chk(addrTag, "gprAddr", longint'(gprAddr), mG);
    chk(addrTag, "miscAddr", longint'(miscAddr), mM);
    chk(tag, "restoreAddr", longint'(restoreAddr), mR);
  endtask

  function automatic longint frameOf(input int idx);
    return ((mBase & ~longint'(4095)) + longint'(idx) * mPages * 4096) & AMASK;
  endfunction

  // one clock: drive strobes, step the model, compare after the edge
  task automatic step(input bit en, input bit ex, input bit rs, input string forceTag);
    string tag, addrTag;
    bit any;
    enterReq = en; exitReq = ex; resumeReq = rs;
    any = en | ex | rs;
    mDone = any;
    mFail = 1'b0;
    tag = "R8";
    if (ex) begin
      if (longint'(mIdx) < mCount) begin
        mX = frameOf(mIdx);
        mG = (mX + mPages * 4096 - 176) & AMASK;
        mM = (mG - mMisc) & AMASK;
        mIdx++;
        tag = "R2";
      end else begin
        mFail = 1'b1;
        tag = "R4";
      end
    end else if (rs) begin
      if (mIdx > 0) begin
        mR = frameOf(mIdx - 1);
        mIdx--;
        tag = "R5";
      end else begin
        mFail = 1'b1;
        tag = "R6";
      end
    end else if (en) begin
      mFail = !(longint'(mIdx) < mCount);
      tag = "R7";
    end
    addrTag = (tag == "R2") ? "R3" : tag;
    if (forceTag != "") begin
      tag = forceTag;
      addrTag = forceTag;
    end
    if (!any) begin
      mBase = longint'(cfgBase); mCount = longint'(cfgFrameCount);
      mPages = longint'(cfgFramePages); mMisc = longint'(cfgMiscBytes);
    end
    @(posedge clk);
    @(negedge clk);
    compareAll(tag, addrTag);
  endtask

  task automatic setCfg(input longint b, input int c, input int p, input int m);
    cfgBase = b[47:0]; cfgFrameCount = c[3:0]; cfgFramePages = p[7:0]; cfgMiscBytes = m[11:0];
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nBad++;
    $display("FAIL R8 watchdog: actual hung expected finished run");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    rst = 1'b1; enterReq = 1'b0; exitReq = 1'b0; resumeReq = 1'b0;
    setCfg(0, 0, 0, 0);
    mIdx = 0; mBase = 0; mCount = 0; mPages = 0; mMisc = 0;
    mX = 0; mG = 0; mM = 0; mR = 0; mDone = 0; mFail = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    compareAll("R1", "R1");               // reset state
    rst = 1'b0;

    // count 0: enter must be refused (R7)
    step(0, 0, 0, "");
    step(1, 0, 0, "");

    // base with junk low bits, 3 frames of 2 pages, 64-byte misc (R2 R3)
    setCfg(64'h0000_1234_5ABC, 3, 2, 64);
    step(0, 0, 0, "");
    step(1, 0, 0, "");
    for (int i = 0; i < 3; i++) step(0, 1, 0, "");
    step(0, 1, 0, "");                    // full stack (R4)
    step(1, 0, 0, "");                    // enter refused when full (R7)
    for (int i = 0; i < 3; i++) step(0, 0, 1, "");
    step(0, 0, 1, "");                    // empty stack (R6)
    step(0, 0, 0, "");

    // config presented only during a strobe cycle must not be taken (R9)
    setCfg(64'h0000_0000_8000, 9, 5, 100);
    step(0, 1, 0, "R9");
    setCfg(64'h0000_1234_5000, 3, 2, 64);
    step(0, 1, 0, "R9");
    step(0, 0, 1, "R9");
    step(0, 0, 1, "R9");
    step(0, 0, 0, "");

    // simultaneous strobes: exit wins (R8)
    step(1, 1, 1, "R8");
    step(0, 0, 1, "R8");

    // mixed traffic
    for (int n = 0; n < 2000; n++) begin
      int r;
      if ($urandom_range(0, 7) == 0)
        setCfg({$urandom(), $urandom()}, $urandom_range(0, 15), $urandom_range(1, 16),
               $urandom_range(0, 4095));
      r = $urandom_range(0, 9);
      if (r < 2)      step(0, 0, 0, "");
      else if (r < 3) step(1, 0, 0, "");
      else if (r < 7) step(0, 1, 0, "");
      else            step(0, 0, 1, "");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule